// File: doc/BRIEF.md
# Video Timing Flag Extractor

This block sits behind a deserializer on a 10-bit parallel video word stream and turns the embedded timing reference sequences into two blanking status flags. The flags are aligned with the data word they describe. It watches the stream for the four-word reference pattern, decodes the ID word that closes it, and produces a horizontal blanking flag and a vertical blanking flag next to a delayed copy of the data. Every register moves only on cycles where the pixel enable is high.

A mode input picks how the horizontal flag is formed. In the first mode it covers the whole horizontal blanking span, both reference sequences included. In the second mode it simply follows the H bit found in each reference ID word. A carrier-loss input comes from an external signal detector and is not synchronous to the pixel clock. When it is high, the outputs are muted and lock is withdrawn. Lock is only granted again after the stream shows clean line structure.

Top module: `vtf_timing_flags`

## Requirements
- R1: A reference sequence is the words 3FFh, 000h, 000h followed by an ID word. In the ID word, bit 6 is H (1 = end of active video, 0 = start of active video) and bit 7 is V. A word sampled on an enabled edge appears on `vid_out` four enabled edges later, unchanged, unless muted.
- R2: With the latched mode at 0, `hblank` is 1 from the 3FFh word of the end-of-active sequence through the ID word of the next start-of-active sequence, and 0 on active words.
- R3: With the latched mode at 1, `hblank` equals the H bit of the most recent ID word, switching on the 3FFh word of that sequence, so start-of-active sequence words carry 0.
- R4: The mode register resets to 0 and loads `hmode_sel` on each enabled edge.
- R5: `vblank` takes the V bit of each end-of-active ID word from that sequence's 3FFh word onward and holds it for the rest of the line.
- R6: While the synchronized `carrier_lost` is 1, each enabled edge drives `vid_out` to MUTE_WORD (default 000h) and `hblank`, `vblank` and `locked` to 0. The input passes two flops first, so the mute reaches the outputs on the third enabled edge after it rises when enables are continuous.
- R7: `locked` rises on the output of the start-of-active 3FFh word of the second consecutive line that has an end-of-active sequence followed by a start-of-active sequence. An end-of-active sequence with no start-of-active since the previous one clears lock and the count. So does carrier loss.
- R8: No output changes on an edge where `pix_en` is 0.
- R9: After reset, `vid_out`, `hblank`, `vblank` and `locked` are all 0.
- R10: If carrier loss and the start-of-active sequence that would grant lock reach the same edge, the mute wins: `locked` stays 0 and two fresh lines are needed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel enable; qualifies every word and state update |
| vid_in | input | 10 | Incoming video word |
| carrier_lost | input | 1 | Asynchronous; 1 marks the input as invalid |
| hmode_sel | input | 1 | Horizontal flag mode: 0 full span, 1 H bit |
| vid_out | output | 10 | Delayed video word, or mute value |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| locked | output | 1 | Line structure lock |

## Verification
Carrier-loss muting and the lock grant can land on the same edge. The lock grant is the start-of-active detection that completes the second good line. The bench provokes the clash by raising `carrier_lost` two enabled edges before the start-of-active ID word is latched, so that the synchronized level arrives exactly as the sequence is recognised. The scoreboard then expects a muted word with `locked` at 0 on that edge and requires two further good lines before lock returns. That shows the mute took priority and also reset the line count.

// File: rtl/vtf_pkg.sv
package vtf_pkg;
  // Length of a timing reference sequence in words (3 preamble + ID).
  localparam int TRS_LEN = 4;

  typedef struct packed {
    logic hit;   // full sequence present in the window
    logic eav;   // sequence with H = 1
    logic sav;   // sequence with H = 0
    logic v;     // V bit of the ID word
    logic h;     // H bit of the ID word
  } trs_evt_t;
endpackage

// File: rtl/vtf_cd_sync.sv
module vtf_cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  // Reset to "invalid" so nothing is trusted before the chain has filled.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/vtf_word_pipe.sv
module vtf_word_pipe #(
  parameter int DW    = 10,
  parameter int DEPTH = vtf_pkg::TRS_LEN
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [DW-1:0]             din,
  output logic [DEPTH-1:0][DW-1:0]  taps   // taps[0] newest
);
  logic [DW-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign taps[g] = stg[g];
  end
endmodule

// File: rtl/vtf_trs_detect.sv
module vtf_trs_detect
  import vtf_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic [TRS_LEN-1:0][DW-1:0] taps,
  output trs_evt_t                   evt
);
  localparam int H_BIT = DW - 4;
  localparam int V_BIT = DW - 3;

  logic preamble;

  always_comb begin
    preamble = (taps[TRS_LEN-1] == {DW{1'b1}});
    for (int i = 1; i < TRS_LEN-1; i++)
      preamble = preamble && (taps[i] == '0);
    evt.hit = preamble;
    evt.h   = taps[0][H_BIT];
    evt.v   = taps[0][V_BIT];
    evt.eav = preamble &&  taps[0][H_BIT];
    evt.sav = preamble && !taps[0][H_BIT];
  end
endmodule

// File: rtl/vtf_lock_fsm.sv
module vtf_lock_fsm #(
  parameter int LOCK_LINES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic mute_i,
  input  logic eav_i,
  input  logic sav_i,
  output logic lock_o
);
  localparam int CW = $clog2(LOCK_LINES + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          saw_eav;

  assign cnt_nxt = (cnt == CW'(LOCK_LINES)) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      saw_eav <= 1'b0;
      lock_o  <= 1'b0;
    end else if (en_i) begin
      if (mute_i) begin
        cnt     <= '0;
        saw_eav <= 1'b0;
        lock_o  <= 1'b0;
      end else if (eav_i) begin
        if (saw_eav) begin          // line without a start-of-active
          cnt    <= '0;
          lock_o <= 1'b0;
        end
        saw_eav <= 1'b1;
      end else if (sav_i) begin
        if (saw_eav) begin
          cnt    <= cnt_nxt;
          lock_o <= (cnt_nxt == CW'(LOCK_LINES));
        end else begin
          cnt    <= '0;
          lock_o <= 1'b0;
        end
        saw_eav <= 1'b0;
      end
    end
  end

  // R7: lock is only ever granted by a start-of-active event on a clean edge
  p_lock_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(sav_i && en_i && !mute_i));

  // R7: the good-line count never runs past its target
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LOCK_LINES));
endmodule

// File: rtl/vtf_timing_flags.sv
module vtf_timing_flags
  import vtf_pkg::*;
#(
  parameter int          DW         = 10,
  parameter int          LOCK_LINES = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [9:0]  MUTE_WORD  = 10'h000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [DW-1:0] vid_in,
  input  logic          carrier_lost,
  input  logic          hmode_sel,
  output logic [DW-1:0] vid_out,
  output logic          hblank,
  output logic          vblank,
  output logic          locked
);
  localparam int TW = $clog2(TRS_LEN);

  logic                        cd_s;
  logic [TRS_LEN-1:0][DW-1:0]  taps;
  trs_evt_t                    evt;
  logic                        mode_q;
  logic                        in_blank;
  logic [TW-1:0]               sav_tail;
  logic                        h_id_q;
  logic                        v_q;
  logic                        h_full, h_idbit, v_word;

  vtf_cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(carrier_lost), .sync_o(cd_s)
  );

  vtf_word_pipe #(.DW(DW), .DEPTH(TRS_LEN)) u_pipe (
    .clk(clk), .rst(rst), .en(pix_en), .din(vid_in), .taps(taps)
  );

  vtf_trs_detect #(.DW(DW)) u_det (
    .taps(taps), .evt(evt)
  );

  vtf_lock_fsm #(.LOCK_LINES(LOCK_LINES)) u_lock (
    .clk(clk), .rst(rst), .en_i(pix_en), .mute_i(cd_s),
    .eav_i(evt.eav), .sav_i(evt.sav), .lock_o(locked)
  );

  // Mode register: resets to full-span mode.
  always_ff @(posedge clk) begin
    if (rst)         mode_q <= 1'b0;
    else if (pix_en) mode_q <= hmode_sel;
  end

  // Line state, tracked for the word currently in the oldest tap.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_blank <= 1'b0;
      sav_tail <= '0;
      h_id_q   <= 1'b0;
      v_q      <= 1'b0;
    end else if (pix_en) begin
      if (evt.eav)      in_blank <= 1'b1;
      else if (evt.sav) in_blank <= 1'b0;

      if (evt.sav)               sav_tail <= TW'(TRS_LEN - 1);
      else if (sav_tail != '0)   sav_tail <= sav_tail - 1'b1;

      if (evt.hit) h_id_q <= evt.h;
      if (evt.eav) v_q    <= evt.v;
    end
  end

  always_comb begin
    h_full  = in_blank || evt.eav || evt.sav || (sav_tail != '0);
    h_idbit = evt.hit ? evt.h : h_id_q;
    v_word  = evt.eav ? evt.v : v_q;
  end

  // Registered outputs, moving only with the pixel enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      vid_out <= '0;
      hblank  <= 1'b0;
      vblank  <= 1'b0;
    end else if (pix_en) begin
      if (cd_s) begin
        vid_out <= DW'(MUTE_WORD);
        hblank  <= 1'b0;
        vblank  <= 1'b0;
      end else begin
        vid_out <= taps[TRS_LEN-1];
        hblank  <= mode_q ? h_idbit : h_full;
        vblank  <= v_word;
      end
    end
  end

  // R8: outputs hold on edges without a pixel enable
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable({vid_out, hblank, vblank, locked}));

  // R6, R10: a synchronized carrier loss mutes everything, lock included
  p_mute_r6: assert property (@(posedge clk) disable iff (rst)
    (pix_en && cd_s) |=> (vid_out == DW'(MUTE_WORD) && !hblank && !vblank && !locked));

  // R2: in full-span mode a start-of-active 3FFh word is still flagged
  p_sav_h_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && evt.sav && pix_en && !cd_s) |=> hblank);

  // R5: the V bit of an end-of-active ID word shows on its first word
  p_v_latch_r5: assert property (@(posedge clk) disable iff (rst)
    (evt.eav && pix_en && !cd_s) |=> (vblank == $past(evt.v)));
endmodule

// File: tb/test_vtf_timing_flags.sv
module test_vtf_timing_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b0;
  logic [9:0] vid_in = '0;
  logic       carrier_lost = 1'b0;
  logic       hmode_sel = 1'b0;
  logic [9:0] vid_out;
  logic       hblank, vblank, locked;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [9:0] d;
    logic       h;
    logic       v;
    logic       lk;
    bit         mute;
    bit         m1;
    string      lreq;
  } exp_t;

  exp_t exp_q[$];

  // bench model of the requirements
  bit    b_inblank = 0, b_saw = 0, b_lock = 0, b_h1 = 0, b_v = 0;
  int    b_cnt = 0, b_tail = 0;
  bit    mute_now = 0, gap_on = 0;
  int    gap_ct = 0;
  string cur_lreq = "R7";

  vtf_timing_flags i_vtf_timing_flags (
    .clk(clk), .rst(rst), .pix_en(pix_en), .vid_in(vid_in),
    .carrier_lost(carrier_lost), .hmode_sel(hmode_sel),
    .vid_out(vid_out), .hblank(hblank), .vblank(vblank), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [9:0] id_word(input bit h, input bit v);
    return 10'h200 | (10'(v) << 7) | (10'(h) << 6);
  endfunction

  // kind: 0 plain, 1 first word of end-of-active, 2 first word of start-of-active
  task automatic drive_word(input logic [9:0] w, input int kind, input bit idv);
    exp_t e;
    bit h0, h1;
    case (kind)
      1: begin
        if (b_saw) begin b_cnt = 0; b_lock = 0; end
        b_saw = 1; b_inblank = 1; b_v = idv; b_h1 = 1;
        h0 = 1; h1 = 1;
      end
      2: begin
        if (b_saw) begin
          if (b_cnt < 2) b_cnt++;
          b_lock = (b_cnt >= 2);
        end else begin
          b_cnt = 0; b_lock = 0;
        end
        b_saw = 0; b_inblank = 0; b_tail = 3; b_h1 = 0;
        h0 = 1; h1 = 0;
      end
      default: begin
        h0 = b_inblank || (b_tail > 0);
        if (b_tail > 0) b_tail--;
        h1 = b_h1;
      end
    endcase
    e.d = w; e.h = hmode_sel ? h1 : h0; e.v = b_v; e.lk = b_lock;
    e.mute = mute_now; e.m1 = hmode_sel; e.lreq = cur_lreq;
    exp_q.push_back(e);
    @(negedge clk);
    vid_in = w;
    pix_en = 1'b1;
    if (gap_on) begin
      gap_ct++;
      if (gap_ct % 3 == 0) begin
        @(negedge clk);
        pix_en = 1'b0;
      end
    end
  endtask

  // raised right after the word latched on edge X: words from X-2 on are muted
  task automatic raise_cd();
    carrier_lost = 1'b1;
    mute_now = 1;
    for (int k = 1; k <= 3; k++) exp_q[exp_q.size()-k].mute = 1;
    b_cnt = 0; b_saw = 0; b_lock = 0;
  endtask

  task automatic drop_cd();
    carrier_lost = 1'b0;
    mute_now = 0;
    for (int k = 1; k <= 3; k++) exp_q[exp_q.size()-k].mute = 0;
  endtask

  task automatic send_line(input bit v, input bit with_sav, input bit cut);
    drive_word(10'h3FF, 1, v);
    drive_word(10'h000, 0, 0);
    drive_word(10'h000, 0, 0);
    drive_word(id_word(1, v), 0, 0);
    for (int i = 0; i < 5; i++) drive_word(10'h040, 0, 0);
    if (with_sav) begin
      drive_word(10'h3FF, 2, v);
      drive_word(10'h000, 0, 0);
      drive_word(10'h000, 0, 0);
      if (cut) raise_cd();           // R10: mute lands on the lock edge
      drive_word(id_word(0, v), 0, 0);
    end
    for (int i = 0; i < 10; i++) begin
      drive_word(10'h100 + 10'(i), 0, 0);
      if (cut && i == 3) drop_cd();
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t       e;
    int         n_en;
    bit         en, have_prev;
    logic [12:0] prev;
    string      hreq, dreq;
    n_en = 0; have_prev = 0; prev = '0;
    forever begin
      @(posedge clk);
      en = pix_en && !rst;
      @(negedge clk);
      if (rst) continue;
      if (!en && have_prev)       // R8
        check({vid_out, hblank, vblank, locked} == prev, "R8", "hold",
              int'({vid_out, hblank, vblank, locked}), int'(prev));
      if (en) begin
        n_en++;
        if (n_en >= 5) begin
          if (exp_q.size() == 0) begin
            check(0, "R1", "queue empty", 0, 1);
          end else begin
            e = exp_q.pop_front();
            if (e.mute) begin
              dreq = (e.lreq == "R10") ? "R10" : "R6";
              check(vid_out == 10'h000, dreq, "muted data", vid_out, 0);
              check(hblank == 0, dreq, "muted hblank", hblank, 0);
              check(vblank == 0, dreq, "muted vblank", vblank, 0);
              check(locked == 0, dreq, "muted lock", locked, 0);
            end else begin
              hreq = e.m1 ? "R3" : "R2";
              check(vid_out == e.d, "R1", "data", vid_out, e.d);
              check(hblank == e.h, hreq, "hblank", hblank, e.h);
              check(vblank == e.v, "R5", "vblank", vblank, e.v);
              check(locked == e.lk, e.lreq, "locked", locked, e.lk);
            end
          end
        end
      end
      prev = {vid_out, hblank, vblank, locked};
      have_prev = 1;
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(vid_out == 0, "R9", "data", vid_out, 0);
    check(hblank == 0,  "R9", "hblank", hblank, 0);
    check(vblank == 0,  "R9", "vblank", vblank, 0);
    check(locked == 0,  "R9", "locked", locked, 0);
    repeat (4) @(negedge clk);

    // idle words before any sequence
    for (int i = 0; i < 6; i++) drive_word(10'h200, 0, 0);

    // R4: hmode_sel held at 0 from reset, so these lines use full-span mode;
    // R7: lock rises on the second good line
    send_line(1, 1, 0);
    send_line(1, 1, 0);
    send_line(1, 1, 0);
    send_line(0, 1, 0);

    // R3: flag follows the ID H bit
    hmode_sel = 1'b1;
    send_line(0, 1, 0);
    send_line(1, 1, 0);

    // R8: enable gaps, both modes
    gap_on = 1;
    send_line(1, 1, 0);
    hmode_sel = 1'b0;
    send_line(0, 1, 0);
    send_line(1, 1, 0);
    gap_on = 0;

    // R7: a line with no start-of-active drops lock
    send_line(0, 0, 0);
    send_line(1, 1, 0);
    send_line(0, 1, 0);

    // R6: plain carrier loss during active video
    for (int i = 0; i < 3; i++) drive_word(10'h200, 0, 0);
    raise_cd();
    for (int i = 0; i < 12; i++) drive_word(10'h200, 0, 0);
    drop_cd();
    for (int i = 0; i < 6; i++) drive_word(10'h200, 0, 0);
    send_line(1, 1, 0);
    send_line(1, 1, 0);

    // R10: carrier loss lands on the edge that would grant lock
    for (int i = 0; i < 3; i++) drive_word(10'h200, 0, 0);
    raise_cd();
    for (int i = 0; i < 8; i++) drive_word(10'h200, 0, 0);
    drop_cd();
    for (int i = 0; i < 6; i++) drive_word(10'h200, 0, 0);
    send_line(0, 1, 0);
    cur_lreq = "R10";
    send_line(1, 1, 1);
    send_line(0, 1, 0);
    send_line(1, 1, 0);
    cur_lreq = "R7";

    for (int i = 0; i < 6; i++) drive_word(10'h200, 0, 0);
    @(negedge clk);
    pix_en = 1'b0;
    repeat (6) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule